// File: doc/BRIEF.md
# Branch and Subroutine Program Counter Unit

This block owns the program counter of a small word-addressed processor with a 12-bit address space. Each cycle it either holds the counter, steps it by one for an instruction fetch, or carries out a decoded control-transfer operation. The operations are a relative jump, four relative jumps that depend on the negative and zero flags, a subroutine call and a subroutine return. Relative targets are the current counter plus a sign-extended offset, and all address arithmetic wraps modulo 4096.

Subroutine linkage runs through a dedicated 16-entry hardware stack of 12-bit return addresses, not through data memory. A call saves the current counter value, which is already the address after the call because the fetch step has advanced it. It then jumps. A return restores the most recently saved address. If a call meets a full stack, or a return meets an empty one, the stack depth stays as it was and a sticky error output rises. Only reset clears it.

The fetch logic drives the increment strobe. The decoder drives the execute strobe, the operation code and the offset. The flags come from the status register.

Top module: `pc_seq_unit`

## Requirements
- R1: While reset is high at a clock edge, the counter becomes 0, the error output becomes 0 and the return stack becomes empty, so that a return issued first after reset reports underflow.
- R2: With the execute strobe low and the increment strobe high, the counter advances by one on the next edge, wrapping from 4095 to 0.
- R3: Operation code 0 (jump) with the execute strobe high loads the counter with the counter plus the 8-bit two's-complement offset sign-extended to 12 bits, modulo 4096.
- R4: Operation codes 1, 2, 3 and 4 jump as in R3 only when, respectively, Z=1, Z=0, N=1 or N=0; otherwise the counter is left unchanged.
- R5: Operation code 5 (call) saves the current counter on the return stack and loads the counter with the R3 target.
- R6: Operation code 6 (return) loads the counter with the most recently saved address and removes it from the stack (last in, first out).
- R7: A call while 16 addresses are held still jumps, but it saves nothing, leaves the depth at 16 and sets the error output. The 16 held addresses come back intact on later returns.
- R8: A return with an empty stack leaves the counter unchanged and sets the error output.
- R9: When the execute strobe is high, the increment strobe is ignored. Operation code 7 is a no-operation that leaves the counter unchanged.
- R10: With both strobes low the counter holds its value.
- R11: Once set, the error output stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| inc_i | input | 1 | Fetch increment strobe |
| exec_i | input | 1 | Execute strobe for the operation on op_i |
| op_i | input | 3 | Operation code (0 jump, 1-4 conditional, 5 call, 6 return, 7 no-op) |
| ofs_i | input | 8 | Signed relative offset |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| pc_o | output | 12 | Current program counter (registered) |
| stk_err_o | output | 1 | Sticky stack overflow/underflow error (registered) |

## Verification
A wrong next-counter choice appears on pc_o one edge after the offending strobe, so those faults surface immediately. A corrupted stack pointer or a clobbered stack entry stays invisible until a later return, which may be many cycles away. The scenarios therefore nest calls, fill the stack completely, and unwind every level, so that each saved address comes back to the ports. A wrong full or empty decision also shows up late, as a missing or spurious rise of stk_err_o or as a wrong address on a later return.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    OP_JMP  = 3'd0,
    OP_JZ   = 3'd1,
    OP_JNZ  = 3'd2,
    OP_JN   = 3'd3,
    OP_JNN  = 3'd4,
    OP_CALL = 3'd5,
    OP_RET  = 3'd6,
    OP_NOP  = 3'd7
  } br_op_e;

endpackage

// File: rtl/pcu_cond.sv
// Evaluates whether a relative transfer is taken.
module pcu_cond
  import pcu_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       flag_n_i,
  input  logic       flag_z_i,
  output logic       take_o
);

  br_op_e op;
  assign op = br_op_e'(op_i);

  always_comb begin
    unique case (op)
      OP_JMP:  take_o = 1'b1;
      OP_JZ:   take_o = flag_z_i;
      OP_JNZ:  take_o = ~flag_z_i;
      OP_JN:   take_o = flag_n_i;
      OP_JNN:  take_o = ~flag_n_i;
      OP_CALL: take_o = 1'b1;
      default: take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcu_target.sv
// Relative target adder: pc + sign-extended offset, wrapping.
module pcu_target #(
  parameter int AW = 12,
  parameter int OW = 8
) (
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] ofs_i,
  output logic [AW-1:0] tgt_o,
  output logic [AW-1:0] seq_o
);

  logic [AW-1:0] ofs_ext;

  generate
    if (OW >= AW) begin : g_trunc
      assign ofs_ext = ofs_i[AW-1:0];
    end else begin : g_sext
      assign ofs_ext = {{(AW-OW){ofs_i[OW-1]}}, ofs_i};
    end
  endgenerate

  assign tgt_o = pc_i + ofs_ext;
  assign seq_o = pc_i + {{(AW-1){1'b0}}, 1'b1};

endmodule

// File: rtl/pcu_retstack.sv
// Return-address stack. DEPTH must be a power of two.
module pcu_retstack #(
  parameter int AW    = 12,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] top_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] count_q;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;
  logic          do_push;
  logic          do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign wr_idx  = count_q[IW-1:0];
  assign rd_idx  = count_q[IW-1:0] - {{(IW-1){1'b0}}, 1'b1};

  // Storage carries no reset so it maps onto plain RAM.
  always_ff @(posedge clk_i) begin
    if (do_push) begin
      mem[wr_idx] <= wdata_i;
    end
  end

  assign top_o = mem[rd_idx];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_q <= '0;
    end else if (do_push) begin
      count_q <= count_q + CW'(1);
    end else if (do_pop) begin
      count_q <= count_q - CW'(1);
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
  import pcu_pkg::*;
#(
  parameter int AW    = 12,
  parameter int OW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          inc_i,
  input  logic          exec_i,
  input  logic [2:0]    op_i,
  input  logic [OW-1:0] ofs_i,
  input  logic          flag_n_i,
  input  logic          flag_z_i,
  output logic [AW-1:0] pc_o,
  output logic          stk_err_o
);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;
  logic          err_q;
  logic          err_d;
  logic [AW-1:0] tgt;
  logic [AW-1:0] seq;
  logic [AW-1:0] stk_top;
  logic [CW-1:0] stk_count;
  logic          stk_full;
  logic          stk_empty;
  logic          take;
  logic          is_call;
  logic          is_ret;
  br_op_e        op;

  assign op      = br_op_e'(op_i);
  assign is_call = exec_i & (op == OP_CALL);
  assign is_ret  = exec_i & (op == OP_RET);

  pcu_cond u_cond (
    .op_i     (op_i),
    .flag_n_i (flag_n_i),
    .flag_z_i (flag_z_i),
    .take_o   (take)
  );

  pcu_target #(.AW(AW), .OW(OW)) u_target (
    .pc_i  (pc_q),
    .ofs_i (ofs_i),
    .tgt_o (tgt),
    .seq_o (seq)
  );

  pcu_retstack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .push_i  (is_call),
    .pop_i   (is_ret),
    .wdata_i (pc_q),
    .top_o   (stk_top),
    .count_o (stk_count),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  always_comb begin
    pc_d = pc_q;
    if (exec_i) begin
      if (op == OP_RET) begin
        pc_d = stk_empty ? pc_q : stk_top;
      end else if (take) begin
        pc_d = tgt;
      end
    end else if (inc_i) begin
      pc_d = seq;
    end
  end

  assign err_d = err_q | (is_call & stk_full) | (is_ret & stk_empty);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= err_d;
    end
  end

  assign pc_o      = pc_q;
  assign stk_err_o = err_q;

endmodule

// File: rtl/pc_seq_unit_chk.sv
module pc_seq_unit_chk #(
  parameter int AW    = 12,
  parameter int OW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          inc_i,
  input logic          exec_i,
  input logic [2:0]    op_i,
  input logic [OW-1:0] ofs_i,
  input logic          flag_n_i,
  input logic          flag_z_i,
  input logic [AW-1:0] pc_o,
  input logic          stk_err_o,
  input logic [CW-1:0] depth
);

  logic [AW-1:0] ofs_ext;
  assign ofs_ext = AW'({{AW{ofs_i[OW-1]}}, ofs_i});

  // R1
  rst_state_chk: assert property (@(posedge clk) rst |=> (pc_o == '0) && !stk_err_o && (depth == '0));

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!exec_i && inc_i) |=> pc_o == AW'($past(pc_o) + AW'(1)));

  // R3
  jump_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 3'd0) |=> pc_o == AW'($past(pc_o) + $past(ofs_ext)));

  // R4
  cond_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 3'd1 && !flag_z_i) |=> pc_o == $past(pc_o));

  // R4
  cond_take_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 3'd3 && flag_n_i) |=> pc_o == AW'($past(pc_o) + $past(ofs_ext)));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 3'd5 && depth == CW'(DEPTH)) |=> (depth == CW'(DEPTH)) && stk_err_o);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 3'd6 && depth == '0) |=> (depth == '0) && stk_err_o && pc_o == $past(pc_o));

  // R9
  nop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 3'd7) |=> pc_o == $past(pc_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!exec_i && !inc_i) |=> $stable(pc_o));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stk_err_o |=> stk_err_o);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    depth <= CW'(DEPTH));

endmodule

bind pc_seq_unit pc_seq_unit_chk #(.AW(AW), .OW(OW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk_i),
  .rst       (rst_i),
  .inc_i     (inc_i),
  .exec_i    (exec_i),
  .op_i      (op_i),
  .ofs_i     (ofs_i),
  .flag_n_i  (flag_n_i),
  .flag_z_i  (flag_z_i),
  .pc_o      (pc_o),
  .stk_err_o (stk_err_o),
  .depth     (stk_count)
);

// File: tb/pc_seq_unit_bench.sv
module pc_seq_unit_bench;

  localparam int AW    = 12;
  localparam int OW    = 8;
  localparam int DEPTH = 16;

  typedef struct {
    logic [AW-1:0] pc;
    logic          err;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inc = 1'b0;
  logic          exec = 1'b0;
  logic [2:0]    op = 3'd7;
  logic [OW-1:0] ofs = '0;
  logic          fn = 1'b0;
  logic          fz = 1'b0;
  logic [AW-1:0] pc;
  logic          err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  exp_t          sb[$];
  logic [AW-1:0] m_pc;
  logic          m_err;
  logic [AW-1:0] m_stk[$];

  always #5 clk = ~clk;

  pc_seq_unit u_pc_seq_unit (
    .clk_i     (clk),
    .rst_i     (rst),
    .inc_i     (inc),
    .exec_i    (exec),
    .op_i      (op),
    .ofs_i     (ofs),
    .flag_n_i  (fn),
    .flag_z_i  (fz),
    .pc_o      (pc),
    .stk_err_o (err)
  );

  // Monitor: compares after each edge has settled.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pc !== e.pc || err !== e.err) begin
        fails++;
        $display("FAIL %s: pc=%0d err=%0b expected pc=%0d err=%0b", e.tag, pc, err, e.pc, e.err);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; inc = 1'b0; exec = 1'b0; op = 3'd7;
    @(negedge clk);
    m_pc = '0; m_err = 1'b0; m_stk.delete();
    sb.push_back('{pc: m_pc, err: m_err, tag: "R1 reset state"});
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic i_inc, input logic i_exec, input logic [2:0] i_op,
                      input logic [OW-1:0] i_ofs, input logic i_n, input logic i_z,
                      input string tag);
    logic [AW-1:0] tgt;
    logic          take;
    @(negedge clk);
    inc = i_inc; exec = i_exec; op = i_op; ofs = i_ofs; fn = i_n; fz = i_z;
    tgt = m_pc + {{(AW-OW){i_ofs[OW-1]}}, i_ofs};
    if (i_exec) begin
      case (i_op)
        3'd0: take = 1'b1;
        3'd1: take = i_z;
        3'd2: take = !i_z;
        3'd3: take = i_n;
        3'd4: take = !i_n;
        default: take = 1'b0;
      endcase
      if (i_op == 3'd5) begin
        if (m_stk.size() < DEPTH) m_stk.push_back(m_pc);
        else m_err = 1'b1;
        m_pc = tgt;
      end else if (i_op == 3'd6) begin
        if (m_stk.size() > 0) m_pc = m_stk.pop_back();
        else m_err = 1'b1;
      end else if (take) begin
        m_pc = tgt;
      end
    end else if (i_inc) begin
      m_pc = m_pc + 12'd1;
    end
    sb.push_back('{pc: m_pc, err: m_err, tag: tag});
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 3'd7, '0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    idle("R10 hold after reset");
    // R8 and R1: first return after reset finds an empty stack
    step(1'b0, 1'b1, 3'd6, '0, 1'b0, 1'b0, "R8 return on empty after reset");
    idle("R11 error remains set");
    do_reset();

    // R2 increments
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'd7, '0, 1'b0, 1'b0, "R2 increment");
    idle("R10 idle hold");
    // R3 forward, backward, wrap below zero and wrap of increment
    step(1'b0, 1'b1, 3'd0, 8'd10, 1'b0, 1'b0, "R3 jump forward");
    step(1'b0, 1'b1, 3'd0, 8'hEC, 1'b0, 1'b0, "R3 jump backward wraps");
    step(1'b0, 1'b1, 3'd0, 8'd6, 1'b0, 1'b0, "R3 jump to top address");
    step(1'b1, 1'b0, 3'd7, '0, 1'b0, 1'b0, "R2 increment wraps to zero");
    step(1'b0, 1'b1, 3'd0, 8'h7F, 1'b0, 1'b0, "R3 largest forward offset");
    step(1'b0, 1'b1, 3'd0, 8'h80, 1'b0, 1'b0, "R3 largest backward offset");

    // R4 every conditional under every flag combination
    for (int c = 1; c <= 4; c++)
      for (int f = 0; f < 4; f++)
        step(1'b0, 1'b1, 3'(c), 8'd3, f[1], f[0], $sformatf("R4 cond op%0d n=%0d z=%0d", c, f[1], f[0]));

    // R9 priority and no-op
    step(1'b1, 1'b1, 3'd0, 8'd20, 1'b0, 1'b0, "R9 exec wins over increment");
    step(1'b1, 1'b1, 3'd1, 8'd20, 1'b0, 1'b0, "R9 untaken branch ignores increment");
    step(1'b1, 1'b1, 3'd7, 8'd20, 1'b1, 1'b1, "R9 no-op holds");

    // R5 / R6 nested calls and returns
    step(1'b0, 1'b1, 3'd5, 8'd40, 1'b0, 1'b0, "R5 call level 1");
    step(1'b1, 1'b0, 3'd7, '0, 1'b0, 1'b0, "R2 increment inside call");
    step(1'b0, 1'b1, 3'd5, 8'hF0, 1'b0, 1'b0, "R5 call level 2");
    step(1'b0, 1'b1, 3'd5, 8'd7, 1'b0, 1'b0, "R5 call level 3");
    step(1'b0, 1'b1, 3'd6, '0, 1'b0, 1'b0, "R6 return level 3");
    step(1'b0, 1'b1, 3'd6, '0, 1'b0, 1'b0, "R6 return level 2");
    step(1'b1, 1'b0, 3'd7, '0, 1'b0, 1'b0, "R2 increment between returns");
    step(1'b0, 1'b1, 3'd6, '0, 1'b0, 1'b0, "R6 return level 1");
    step(1'b0, 1'b1, 3'd6, '0, 1'b0, 1'b0, "R8 return on empty");
    step(1'b0, 1'b1, 3'd0, 8'd9, 1'b0, 1'b0, "R11 error sticky across jump");
    step(1'b0, 1'b1, 3'd5, 8'd2, 1'b0, 1'b0, "R11 error sticky across call");
    step(1'b0, 1'b1, 3'd6, '0, 1'b0, 1'b0, "R6 return after error");

    // R7 fill the stack, overflow, then unwind every level
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, 3'd7, '0, 1'b0, 1'b0, "R2 increment before call");
      step(1'b0, 1'b1, 3'd5, 8'd5, 1'b0, 1'b0, "R5 call while filling");
    end
    step(1'b0, 1'b1, 3'd5, 8'd33, 1'b0, 1'b0, "R7 call on full stack");
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, 1'b1, 3'd6, '0, 1'b0, 1'b0, "R7 return keeps saved addresses");
    step(1'b0, 1'b1, 3'd6, '0, 1'b0, 1'b0, "R8 return after unwinding");
    do_reset();
    idle("R1 error cleared by reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule